// File: doc/BRIEF.md
# Software Write-Protect Command Sequencer

This block sits in front of the write controller of a byte-wide EEPROM model and classifies every byte write it sees. Each write (address plus data, qualified by a one-cycle valid strobe) is judged to be stored in the array, dropped because it is part of a command sequence, or blocked because software protection is active. The block also keeps and exports the protection flag itself.

Two command sequences are recognised. A three-byte prefix (0xAA at 0x1555, 0x55 at 0x0AAA, 0xA0 at 0x1555) turns protection on and lets exactly the next write through. A six-byte sequence (0xAA at 0x1555, 0x55 at 0x0AAA, 0x80 at 0x1555, 0xAA at 0x1555, 0x55 at 0x0AAA, 0x20 at 0x1555) turns protection off. Both start with the same two bytes; the third byte chooses the branch. A timeout pulse from the page controller, raised when the gap between loads runs too long, abandons any partly matched sequence.

Top module: `wp_seq_top`

## Requirements
- R1: After reset the protection flag is 0 and no verdict is valid.
- R2: With protection off, a write that does not match a command byte is reported as stored.
- R3: The three prefix bytes are each reported as dropped; the protection flag becomes 1 with the verdict of the 0xA0 byte.
- R4: The first write after a complete prefix is reported as stored, whatever its address and data, and the protection flag stays 1.
- R5: With protection on, a write not preceded by the prefix is reported as blocked.
- R6: All six disable bytes are reported as dropped; the flag becomes 0 with the verdict of the 0x20 byte, and later ordinary writes are stored.
- R7: A byte that breaks a partly matched sequence returns the machine to idle and is judged as an ordinary write under the current protection flag.
- R8: A timeout pulse abandons a partly matched sequence, so the next byte is judged from idle.
- R9: Each write yields exactly one of stored, dropped or blocked, valid in the cycle after the write, and no verdict appears without a write.
- R10: A third byte of 0x80 at 0x1555 diverts to the disable path and leaves the protection flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrValid | input | 1 | One-cycle strobe marking a byte write |
| wrAddr | input | 13 | Byte address of the write |
| wrData | input | 8 | Data byte of the write |
| windowTimeout | input | 1 | Load-window expiry pulse from the page controller |
| verdictValid | output | 1 | A verdict for the previous cycle's write is present |
| storeEn | output | 1 | Verdict: store the byte |
| dropEn | output | 1 | Verdict: byte consumed as a command |
| blockEn | output | 1 | Verdict: byte refused by protection |
| protectOn | output | 1 | Software protection flag |

## Verification
Every verdict and any change of the protection flag is registered once, so both are due one clock edge after the write that causes them. The driver presents a write on a falling edge, queues the expected verdict and flag, and the monitor compares at the following falling edge, half a cycle after the result settles. A verdict with nothing queued, or a queued item left over at the end, counts as a failure, which also catches verdicts that appear without a write.

// File: rtl/wp_seq_pkg.sv
package wp_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_KEY1,
    ST_KEY2,
    ST_ARMED,
    ST_OFF3,
    ST_OFF4,
    ST_OFF5
  } seqState_t;

  // byte comparisons produced by the datapath
  typedef struct packed {
    logic keyLead;   // first unlock byte
    logic keySecond; // second unlock byte
    logic codeOn;    // third byte selecting protect-on
    logic codeOff;   // third byte selecting the disable path
    logic codeFinal; // last byte of the disable path
  } byteMatch_t;

  // strobes from control to datapath
  typedef struct packed {
    logic store;
    logic drop;
    logic ordinary;
    logic setProt;
    logic clrProt;
  } seqStrobe_t;

endpackage

// File: rtl/wp_seq_ctrl.sv
module wp_seq_ctrl
  import wp_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrValid,
  input  logic       windowTimeout,
  input  byteMatch_t match,
  output seqStrobe_t strobe
);

  seqState_t state, nextState, effState;

  always_comb begin
    effState  = windowTimeout ? ST_IDLE : state;
    nextState = effState;
    strobe    = '0;
    if (wrValid) begin
      nextState = ST_IDLE;
      unique case (effState)
        ST_IDLE: begin
          if (match.keyLead) begin
            strobe.drop = 1'b1;
            nextState   = ST_KEY1;
          end else begin
            strobe.ordinary = 1'b1;
          end
        end
        ST_KEY1: begin
          if (match.keySecond) begin
            strobe.drop = 1'b1;
            nextState   = ST_KEY2;
          end else begin
            strobe.ordinary = 1'b1;
          end
        end
        ST_KEY2: begin
          if (match.codeOn) begin
            strobe.drop    = 1'b1;
            strobe.setProt = 1'b1;
            nextState      = ST_ARMED;
          end else if (match.codeOff) begin
            strobe.drop = 1'b1;
            nextState   = ST_OFF3;
          end else begin
            strobe.ordinary = 1'b1;
          end
        end
        ST_ARMED: begin
          strobe.store = 1'b1;
        end
        ST_OFF3: begin
          if (match.keyLead) begin
            strobe.drop = 1'b1;
            nextState   = ST_OFF4;
          end else begin
            strobe.ordinary = 1'b1;
          end
        end
        ST_OFF4: begin
          if (match.keySecond) begin
            strobe.drop = 1'b1;
            nextState   = ST_OFF5;
          end else begin
            strobe.ordinary = 1'b1;
          end
        end
        ST_OFF5: begin
          if (match.codeFinal) begin
            strobe.drop    = 1'b1;
            strobe.clrProt = 1'b1;
          end else begin
            strobe.ordinary = 1'b1;
          end
        end
        default: strobe.ordinary = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

endmodule

// File: rtl/wp_seq_dp.sv
module wp_seq_dp
  import wp_seq_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] ADDR_HI = 13'h1555,
  parameter logic [ADDR_W-1:0] ADDR_LO = 13'h0AAA,
  parameter logic [DATA_W-1:0] KEY_A   = 8'hAA,
  parameter logic [DATA_W-1:0] KEY_B   = 8'h55,
  parameter logic [DATA_W-1:0] CODE_ON = 8'hA0,
  parameter logic [DATA_W-1:0] CODE_OFF = 8'h80,
  parameter logic [DATA_W-1:0] CODE_END = 8'h20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  seqStrobe_t        strobe,
  output byteMatch_t        match,
  output logic              verdictValid,
  output logic              storeEn,
  output logic              dropEn,
  output logic              blockEn,
  output logic              protectOn
);

  logic atHi, atLo;

  always_comb begin
    atHi            = (wrAddr == ADDR_HI);
    atLo            = (wrAddr == ADDR_LO);
    match.keyLead   = atHi && (wrData == KEY_A);
    match.keySecond = atLo && (wrData == KEY_B);
    match.codeOn    = atHi && (wrData == CODE_ON);
    match.codeOff   = atHi && (wrData == CODE_OFF);
    match.codeFinal = atHi && (wrData == CODE_END);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      protectOn    <= 1'b0;
      verdictValid <= 1'b0;
      storeEn      <= 1'b0;
      dropEn       <= 1'b0;
      blockEn      <= 1'b0;
    end else begin
      if (strobe.setProt)      protectOn <= 1'b1;
      else if (strobe.clrProt) protectOn <= 1'b0;
      storeEn      <= strobe.store || (strobe.ordinary && !protectOn);
      blockEn      <= strobe.ordinary && protectOn;
      dropEn       <= strobe.drop;
      verdictValid <= strobe.store || strobe.drop || strobe.ordinary;
    end
  end

endmodule

// File: rtl/wp_seq_top.sv
module wp_seq_top
  import wp_seq_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrValid,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              windowTimeout,
  output logic              verdictValid,
  output logic              storeEn,
  output logic              dropEn,
  output logic              blockEn,
  output logic              protectOn
);

  byteMatch_t match;
  seqStrobe_t strobe;

  wp_seq_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .wrValid      (wrValid),
    .windowTimeout(windowTimeout),
    .match        (match),
    .strobe       (strobe)
  );

  wp_seq_dp #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .wrAddr      (wrAddr),
    .wrData      (wrData),
    .strobe      (strobe),
    .match       (match),
    .verdictValid(verdictValid),
    .storeEn     (storeEn),
    .dropEn      (dropEn),
    .blockEn     (blockEn),
    .protectOn   (protectOn)
  );

endmodule

// File: rtl/wp_seq_check.sv
module wp_seq_check (
  input logic clk,
  input logic rstN,
  input logic wrValid,
  input logic verdictValid,
  input logic storeEn,
  input logic dropEn,
  input logic blockEn,
  input logic protectOn
);

  p_one_verdict_r9: assert property (@(posedge clk) disable iff (!rstN)
    verdictValid |-> $countones({storeEn, dropEn, blockEn}) == 1);

  p_none_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    !verdictValid |-> !(storeEn || dropEn || blockEn));

  p_write_gives_verdict_r9: assert property (@(posedge clk) disable iff (!rstN)
    wrValid |=> verdictValid);

  p_no_write_no_verdict_r9: assert property (@(posedge clk) disable iff (!rstN)
    !wrValid |=> !verdictValid);

  p_rise_on_cmd_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(protectOn) |-> dropEn);

  p_fall_on_cmd_r6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(protectOn) |-> dropEn);

  p_block_needs_prot_r5: assert property (@(posedge clk) disable iff (!rstN)
    blockEn |-> protectOn);

  p_prot_held_r4: assert property (@(posedge clk) disable iff (!rstN)
    !dropEn |-> $stable(protectOn));

endmodule

bind wp_seq_top wp_seq_check u_check (
  .clk         (clk),
  .rstN        (rstN),
  .wrValid     (wrValid),
  .verdictValid(verdictValid),
  .storeEn     (storeEn),
  .dropEn      (dropEn),
  .blockEn     (blockEn),
  .protectOn   (protectOn)
);

// File: tb/wp_seq_top_test.sv
module wp_seq_top_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrValid = 1'b0;
  logic [12:0] wrAddr = '0;
  logic [7:0]  wrData = '0;
  logic        windowTimeout = 1'b0;
  logic        verdictValid, storeEn, dropEn, blockEn, protectOn;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // expected item: {store, drop, block, protect}
  localparam logic [3:0] ST0 = 4'b1000, ST1 = 4'b1001;
  localparam logic [3:0] DR0 = 4'b0100, DR1 = 4'b0101;
  localparam logic [3:0] BL1 = 4'b0011;

  logic [3:0] expQ[$];
  string      tagQ[$];

  always #5 clk = ~clk;

  wp_seq_top uut (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrAddr(wrAddr),
    .wrData(wrData), .windowTimeout(windowTimeout),
    .verdictValid(verdictValid), .storeEn(storeEn), .dropEn(dropEn),
    .blockEn(blockEn), .protectOn(protectOn)
  );

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // monitor: result of a write is due one edge later
  always @(negedge clk) begin
    if (rstN && !done && verdictValid) begin
      if (expQ.size() == 0) begin
        check("R9 unexpected verdict", {storeEn, dropEn, blockEn, protectOn}, 4'b0000);
      end else begin
        check(tagQ.pop_front(), {storeEn, dropEn, blockEn, protectOn}, expQ.pop_front());
      end
    end
  end

  task automatic doWrite(input logic [12:0] a, input logic [7:0] d,
                         input logic [3:0] exp, input string tag);
    @(negedge clk);
    wrValid = 1'b1; wrAddr = a; wrData = d;
    expQ.push_back(exp); tagQ.push_back(tag);
    @(negedge clk);
    wrValid = 1'b0;
  endtask

  task automatic pulseTimeout();
    @(negedge clk);
    windowTimeout = 1'b1;
    @(negedge clk);
    windowTimeout = 1'b0;
  endtask

  task automatic prefix(input logic [3:0] e1, input logic [3:0] e2, input logic [3:0] e3);
    doWrite(13'h1555, 8'hAA, e1, "R3 prefix byte 1");
    doWrite(13'h0AAA, 8'h55, e2, "R3 prefix byte 2");
    doWrite(13'h1555, 8'hA0, e3, "R3 prefix byte 3");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 reset state", {verdictValid, protectOn, 2'b00}, 4'b0000);

    doWrite(13'h0100, 8'h12, ST0, "R2 plain store");
    doWrite(13'h1FFF, 8'hAA, ST0, "R2 near-key store");

    // R7: broken unprotected sequence
    doWrite(13'h1555, 8'hAA, DR0, "R7 first key");
    doWrite(13'h0AAA, 8'h33, ST0, "R7 mismatch stored");

    // R3 and R4
    prefix(DR0, DR0, DR1);
    doWrite(13'h0200, 8'h77, ST1, "R4 guarded write");
    repeat (2) @(negedge clk);

    doWrite(13'h0300, 8'h66, BL1, "R5 unguarded blocked");

    // R8: timeout between command bytes
    doWrite(13'h1555, 8'hAA, DR1, "R8 first key");
    pulseTimeout();
    doWrite(13'h0AAA, 8'h55, BL1, "R8 after timeout");

    // R7: mismatch on third byte while protected
    doWrite(13'h1555, 8'hAA, DR1, "R7 key 1");
    doWrite(13'h0AAA, 8'h55, DR1, "R7 key 2");
    doWrite(13'h1555, 8'h99, BL1, "R7 bad third blocked");

    prefix(DR1, DR1, DR1);
    doWrite(13'h1555, 8'h3C, ST1, "R4 guarded write at key addr");
    doWrite(13'h0004, 8'h01, BL1, "R5 second write blocked");

    // R6 and R10
    doWrite(13'h1555, 8'hAA, DR1, "R6 off byte 1");
    doWrite(13'h0AAA, 8'h55, DR1, "R6 off byte 2");
    doWrite(13'h1555, 8'h80, DR1, "R10 branch keeps flag");
    doWrite(13'h1555, 8'hAA, DR1, "R6 off byte 4");
    doWrite(13'h0AAA, 8'h55, DR1, "R6 off byte 5");
    doWrite(13'h1555, 8'h20, DR0, "R6 off byte 6 clears");
    doWrite(13'h0400, 8'h5A, ST0, "R6 store after clear");

    repeat (3) @(negedge clk);
    check("R9 all verdicts seen", {expQ.size() == 0, 3'b000}, 4'b1000);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog R9 actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule